// File: doc/BRIEF.md
# Windowed Question-Answer Watchdog Controller

This block times the watchdog windows of a safety supervisor and judges every answer the host writes. After the reset output is released, a single fully open initialization window runs. A correct answer there moves the block into normal refresh mode. A wrong answer, or no answer before the window expires, requests a reset and counts a reset error. In normal mode each window period is split into two equal halves: a closed half followed by an open half. A correct answer in the open half is a good refresh. A wrong answer, an answer written during the closed half, or no answer by the end of the open half is an error. Each error increments the watchdog error counter and pulses the interrupt. Every answer and every timeout restarts the window at the start of the closed half.

Timing runs from a time-base strobe `tick`. One tick stands for half a millisecond, so each half of a window lasts as many ticks as the period has milliseconds. A bench can speed the strobe up to shorten a run. The period is chosen by a 4-bit code. A new code is taken up only at the next answer write or the next timeout. The one exception is the return from the inhibited state: the new code then takes effect at once. The watchdog is inhibited by a disable input. It is also inhibited by a debug strap, which is sampled on the first clock after reset.

The states are INIT, CLOSED, OPEN, RESET and OFF. The transitions are as follows:
- INIT→CLOSED on a correct answer.
- INIT→RESET on a wrong answer or when the initialization window expires.
- CLOSED→CLOSED on any write, which is an error.
- CLOSED→OPEN when the closed half ends.
- OPEN→CLOSED on any write or on a timeout.
- RESET→INIT after the reset hold time.
- Any state→OFF while the watchdog is inhibited.
- OFF→CLOSED when the inhibit is lifted.

Top module: `qa_wdog`

## Requirements
- R1: The period code selects the window period in milliseconds, and each half lasts that many ticks. The codes are: 0→1, 1→2, 2→3, 3→4, 4→6, 5→8, 6→12, 7→16, 8→24, 9→32, 10→64, 11→128, 12→256, 13→512, 14→1024 and 15→1024. The internal period resets to code 2 (3 ms).
- R2: In normal mode, `window_open` is 0 during the closed half and 1 during the open half. The closed half always comes first.
- R3: A write (`refresh`=1) during the closed half is a wrong refresh, whatever the value of `answer_ok`.
- R4: Every write in normal mode, good or bad, restarts the window at the start of the closed half.
- R5: After reset, the block is in INIT with `window_open`=1 and all counters at 0. INIT stays open for up to INIT_TICKS ticks (default 512, which is 256 ms). A correct answer in INIT pulses `refresh_good` and enters CLOSED.
- R6: In INIT, a wrong answer or the INIT_TICKS-th tick with no answer does the following:
  - it raises `reset_req` for RST_TICKS ticks (default 4), then returns to INIT;
  - it increments `rst_err_cnt` by one;
  - it does not pulse `irq`.
- R7: In normal mode, a wrong refresh or a timeout pulses both `refresh_bad` and `irq` for one cycle. It also increments `wd_err_cnt`, which saturates at all ones. A timeout is the last tick of the open half arriving with no write.
- R8: A changed period code takes effect only at the next write or the next timeout.
- R9: Leaving OFF loads the current period code at once and starts a closed half.
- R10: While `wd_disable`=1, or when `debug_strap` was 1 on the first clock after reset:
  - the block stays in OFF, with `window_open`=0 and `reset_req`=0;
  - writes are ignored: no pulse and no count.
- R11: A write in the same cycle as the last tick of the open half is judged as a write, and no timeout is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe, one per half millisecond |
| refresh | input | 1 | One-cycle strobe for a write to the answer register |
| answer_ok | input | 1 | Result of the challenge check, valid with `refresh` |
| period_sel | input | 4 | Window period code |
| wd_disable | input | 1 | Inhibits the watchdog while high |
| debug_strap | input | 1 | Debug inhibit strap, sampled once after reset |
| window_open | output | 1 | High in the INIT window and in the open half |
| refresh_good | output | 1 | One-cycle pulse for an accepted answer |
| refresh_bad | output | 1 | One-cycle pulse for a wrong refresh or a timeout |
| irq | output | 1 | One-cycle interrupt pulse for a normal-mode error |
| reset_req | output | 1 | Reset request after an initialization failure |
| wd_err_cnt | output | ERR_W | Saturating watchdog error count |
| rst_err_cnt | output | ERR_W | Saturating reset error count |

## Verification
The end of the open half and an answer write can land in the same clock cycle. The bench provokes this by raising `tick` and `refresh` together on the last tick of an open half. It then checks that only `refresh_good` pulses, that `irq` stays low and that `wd_err_cnt` is unchanged. A second overlap is also checked: a period change written while a window runs must wait for the next write. This is judged by counting how many ticks the following closed half lasts.

// File: rtl/qa_wdog_pkg.sv
package qa_wdog_pkg;

    typedef enum logic [2:0] {
        WS_INIT   = 3'd0,
        WS_CLOSED = 3'd1,
        WS_OPEN   = 3'd2,
        WS_RESET  = 3'd3,
        WS_OFF    = 3'd4
    } wd_state_t;

    // Window period in milliseconds for a 4-bit code
    function automatic logic [10:0] period_ms(input logic [3:0] code);
        logic [10:0] ms;
        unique case (code)
            4'd0:    ms = 11'd1;
            4'd1:    ms = 11'd2;
            4'd2:    ms = 11'd3;
            4'd3:    ms = 11'd4;
            4'd4:    ms = 11'd6;
            4'd5:    ms = 11'd8;
            4'd6:    ms = 11'd12;
            4'd7:    ms = 11'd16;
            4'd8:    ms = 11'd24;
            4'd9:    ms = 11'd32;
            4'd10:   ms = 11'd64;
            4'd11:   ms = 11'd128;
            4'd12:   ms = 11'd256;
            4'd13:   ms = 11'd512;
            default: ms = 11'd1024;
        endcase
        return ms;
    endfunction

endpackage

// File: rtl/qa_wdog_half_lut.sv
module qa_wdog_half_lut #(
    parameter int CNT_W = 11
) (
    input  logic [3:0]       sel,
    output logic [CNT_W-1:0] half_ticks
);
    import qa_wdog_pkg::*;

    always_comb begin
        half_ticks = CNT_W'(period_ms(sel));
    end

    // R1: a half never has zero length
    always_comb begin
        assert_half_nonzero_R1: assert (half_ticks != '0);
    end
endmodule

// File: rtl/qa_wdog_sat_cnt.sv
module qa_wdog_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CMAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != CMAX)
            count <= count + W'(1);
    end

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count != CMAX) |=> (count == $past(count) + W'(1)));

    assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc) |=> $stable(count));
endmodule

// File: rtl/qa_wdog_fsm.sv
module qa_wdog_fsm
    import qa_wdog_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int INIT_TICKS = 512,
    parameter int RST_TICKS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             inhibit,
    input  logic             tick,
    input  logic             refresh,
    input  logic             answer_ok,
    input  logic [CNT_W-1:0] half_ticks,
    output logic             apply_sel,
    output logic             wd_inc,
    output logic             rst_inc,
    output logic             good_o,
    output logic             bad_o,
    output logic             irq_o,
    output logic             window_open,
    output logic             reset_req
);
    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_TICKS - 1);
    localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_TICKS - 1);

    wd_state_t        state, nxt;
    logic [CNT_W-1:0] cnt, ncnt;
    logic             good_n, bad_n, irq_n;
    logic             half_end;

    assign half_end = tick && (cnt >= half_ticks - CNT_W'(1));

    // Next-state and event decode
    always_comb begin
        nxt       = state;
        ncnt      = cnt;
        good_n    = 1'b0;
        bad_n     = 1'b0;
        irq_n     = 1'b0;
        wd_inc    = 1'b0;
        rst_inc   = 1'b0;
        apply_sel = 1'b0;
        if (!armed) begin
            nxt = state;
        end else if (inhibit) begin
            nxt  = WS_OFF;
            ncnt = '0;
        end else begin
            unique case (state)
                WS_INIT: begin
                    if (refresh) begin
                        ncnt = '0;
                        if (answer_ok) begin
                            good_n    = 1'b1;
                            apply_sel = 1'b1;
                            nxt       = WS_CLOSED;
                        end else begin
                            bad_n   = 1'b1;
                            rst_inc = 1'b1;
                            nxt     = WS_RESET;
                        end
                    end else if (tick) begin
                        if (cnt >= INIT_LAST) begin
                            rst_inc = 1'b1;
                            nxt     = WS_RESET;
                            ncnt    = '0;
                        end else begin
                            ncnt = cnt + CNT_W'(1);
                        end
                    end
                end
                WS_CLOSED: begin
                    if (refresh) begin
                        bad_n     = 1'b1;
                        irq_n     = 1'b1;
                        wd_inc    = 1'b1;
                        apply_sel = 1'b1;
                        ncnt      = '0;
                    end else if (half_end) begin
                        nxt  = WS_OPEN;
                        ncnt = '0;
                    end else if (tick) begin
                        ncnt = cnt + CNT_W'(1);
                    end
                end
                WS_OPEN: begin
                    if (refresh || half_end) begin
                        apply_sel = 1'b1;
                        nxt       = WS_CLOSED;
                        ncnt      = '0;
                        if (refresh && answer_ok) begin
                            good_n = 1'b1;
                        end else begin
                            bad_n  = 1'b1;
                            irq_n  = 1'b1;
                            wd_inc = 1'b1;
                        end
                    end else if (tick) begin
                        ncnt = cnt + CNT_W'(1);
                    end
                end
                WS_RESET: begin
                    if (tick) begin
                        if (cnt >= RST_LAST) begin
                            nxt  = WS_INIT;
                            ncnt = '0;
                        end else begin
                            ncnt = cnt + CNT_W'(1);
                        end
                    end
                end
                WS_OFF: begin
                    apply_sel = 1'b1;
                    nxt       = WS_CLOSED;
                    ncnt      = '0;
                end
                default: begin
                    nxt  = WS_INIT;
                    ncnt = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WS_INIT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= ncnt;
        end
    end

    // Output register for event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_o <= 1'b0;
            bad_o  <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            good_o <= good_n;
            bad_o  <= bad_n;
            irq_o  <= irq_n;
        end
    end

    assign window_open = (state == WS_INIT) || (state == WS_OPEN);
    assign reset_req   = (state == WS_RESET);

    assert_closed_write_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !inhibit && state == WS_CLOSED && refresh) |=> (bad_o && !good_o));

    assert_restart_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !inhibit && (state == WS_CLOSED || state == WS_OPEN) && refresh)
        |=> (!window_open && !reset_req));

    assert_init_fail_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !inhibit && state == WS_INIT && refresh && !answer_ok)
        |=> (reset_req && !irq_o));

    assert_open_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !inhibit && state == WS_OPEN && refresh && answer_ok)
        |=> (good_o && !bad_o && !irq_o));

    assert_inhibit_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && inhibit) |=> (!good_o && !bad_o && !reset_req && !window_open));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o || $past(refresh) || $past(tick));
endmodule

// File: rtl/qa_wdog.sv
module qa_wdog #(
    parameter int CNT_W      = 11,
    parameter int ERR_W      = 8,
    parameter int INIT_TICKS = 512,
    parameter int RST_TICKS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             refresh,
    input  logic             answer_ok,
    input  logic [3:0]       period_sel,
    input  logic             wd_disable,
    input  logic             debug_strap,
    output logic             window_open,
    output logic             refresh_good,
    output logic             refresh_bad,
    output logic             irq,
    output logic             reset_req,
    output logic [ERR_W-1:0] wd_err_cnt,
    output logic [ERR_W-1:0] rst_err_cnt
);
    localparam logic [3:0] DEFAULT_SEL = 4'd2;

    logic             armed, strap_q, inhibit;
    logic [3:0]       active_sel;
    logic [CNT_W-1:0] half_ticks;
    logic             apply_sel, wd_inc, rst_inc;

    // Strap capture on the first clock after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            strap_q <= 1'b0;
        end else if (!armed) begin
            armed   <= 1'b1;
            strap_q <= debug_strap;
        end
    end

    assign inhibit = wd_disable || strap_q;

    // Period in force, updated only at the restart points
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            active_sel <= DEFAULT_SEL;
        else if (apply_sel)
            active_sel <= period_sel;
    end

    qa_wdog_half_lut #(.CNT_W(CNT_W)) u_lut (
        .sel        (active_sel),
        .half_ticks (half_ticks)
    );

    qa_wdog_fsm #(
        .CNT_W      (CNT_W),
        .INIT_TICKS (INIT_TICKS),
        .RST_TICKS  (RST_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed       (armed),
        .inhibit     (inhibit),
        .tick        (tick),
        .refresh     (refresh),
        .answer_ok   (answer_ok),
        .half_ticks  (half_ticks),
        .apply_sel   (apply_sel),
        .wd_inc      (wd_inc),
        .rst_inc     (rst_inc),
        .good_o      (refresh_good),
        .bad_o       (refresh_bad),
        .irq_o       (irq),
        .window_open (window_open),
        .reset_req   (reset_req)
    );

    qa_wdog_sat_cnt #(.W(ERR_W)) u_wd_err (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wd_inc),
        .count (wd_err_cnt)
    );

    qa_wdog_sat_cnt #(.W(ERR_W)) u_rst_err (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rst_inc),
        .count (rst_err_cnt)
    );

    // R8: the period in force only moves at a restart point
    assert_sel_deferred_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply_sel) |=> $stable(active_sel));
endmodule

// File: tb/qa_wdog_bench.sv
module qa_wdog_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, refresh = 1'b0, answer_ok = 1'b0;
    logic [3:0] period_sel = 4'd0;
    logic       wd_disable = 1'b0, debug_strap = 1'b0;
    logic       window_open, refresh_good, refresh_bad, irq, reset_req;
    logic [7:0] wd_err_cnt, rst_err_cnt;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    qa_wdog u_qa_wdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .refresh(refresh),
        .answer_ok(answer_ok), .period_sel(period_sel), .wd_disable(wd_disable),
        .debug_strap(debug_strap), .window_open(window_open),
        .refresh_good(refresh_good), .refresh_bad(refresh_bad), .irq(irq),
        .reset_req(reset_req), .wd_err_cnt(wd_err_cnt), .rst_err_cnt(rst_err_cnt)
    );

    // op[12:11] 0=tick 1=good write 2=bad write; [10] good [9] bad/irq [8] open [7:0] wd errors
    localparam logic [12:0] VEC [0:8] = '{
        {2'd1, 1'b0, 1'b1, 1'b0, 8'd1},  // R3 write in closed half
        {2'd0, 1'b0, 1'b0, 1'b1, 8'd1},  // R2 open half reached
        {2'd1, 1'b1, 1'b0, 1'b0, 8'd1},  // R4 good write restarts
        {2'd0, 1'b0, 1'b0, 1'b1, 8'd1},  // R2
        {2'd2, 1'b0, 1'b1, 1'b0, 8'd2},  // R7 wrong answer in open half
        {2'd0, 1'b0, 1'b0, 1'b1, 8'd2},  // R2
        {2'd0, 1'b0, 1'b1, 1'b0, 8'd3},  // R7 timeout
        {2'd0, 1'b0, 1'b0, 1'b1, 8'd3},  // R2
        {2'd1, 1'b1, 1'b0, 1'b0, 8'd3}   // R1 code 0 halves of one tick
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic do_write(input logic ok);
        refresh = 1'b1;
        answer_ok = ok;
        step();
        refresh = 1'b0;
        answer_ok = 1'b0;
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0;
        debug_strap = strap;
        repeat (3) step();
        rst_n = 1'b1;
        repeat (2) step();
    endtask

    initial begin
        do_reset(1'b0);
        chk("R5", "init open", int'(window_open), 1);
        chk("R5", "reset_req idle", int'(reset_req), 0);
        chk("R5", "wd errors", int'(wd_err_cnt), 0);
        chk("R5", "rst errors", int'(rst_err_cnt), 0);

        // R6 wrong answer in INIT
        do_write(1'b0);
        chk("R6", "reset_req after wrong", int'(reset_req), 1);
        chk("R6", "rst errors", int'(rst_err_cnt), 1);
        chk("R6", "no irq in init", int'(irq), 0);
        repeat (3) do_tick();
        chk("R6", "reset held", int'(reset_req), 1);
        do_tick();
        chk("R6", "reset released", int'(reset_req), 0);
        chk("R6", "back to init", int'(window_open), 1);

        // R6 initialization timeout boundary
        repeat (511) do_tick();
        chk("R6", "still open at 511", int'(reset_req), 0);
        do_tick();
        chk("R6", "timeout reset", int'(reset_req), 1);
        chk("R6", "rst errors 2", int'(rst_err_cnt), 2);
        repeat (4) do_tick();

        // R5 correct answer ends INIT
        do_write(1'b1);
        chk("R5", "good pulse", int'(refresh_good), 1);
        chk("R5", "closed after init", int'(window_open), 0);
        step();
        chk("R5", "pulse one cycle", int'(refresh_good), 0);

        // Vector table walk, period code 0
        for (int i = 0; i < 9; i++) begin
            logic [12:0] v;
            v = VEC[i];
            unique case (v[12:11])
                2'd0:    do_tick();
                2'd1:    do_write(1'b1);
                default: do_write(1'b0);
            endcase
            chk("R7", $sformatf("vec%0d good", i), int'(refresh_good), int'(v[10]));
            chk("R7", $sformatf("vec%0d bad", i), int'(refresh_bad), int'(v[9]));
            chk("R7", $sformatf("vec%0d irq", i), int'(irq), int'(v[9]));
            chk("R2", $sformatf("vec%0d open", i), int'(window_open), int'(v[8]));
            chk("R7", $sformatf("vec%0d errs", i), int'(wd_err_cnt), int'(v[7:0]));
        end

        // R8 period change deferred
        period_sel = 4'd1;
        do_tick();
        chk("R8", "old period still used", int'(window_open), 1);
        do_write(1'b1);
        do_tick();
        chk("R8", "new closed half longer", int'(window_open), 0);
        do_tick();
        chk("R8", "open after two ticks", int'(window_open), 1);

        // R11 write on the last tick of the open half
        do_tick();
        chk("R11", "open before last", int'(window_open), 1);
        tick = 1'b1;
        do_write(1'b1);
        tick = 1'b0;
        chk("R11", "good wins", int'(refresh_good), 1);
        chk("R11", "no bad", int'(refresh_bad), 0);
        chk("R11", "errors unchanged", int'(wd_err_cnt), 3);

        // R10 disable input
        wd_disable = 1'b1;
        step();
        chk("R10", "off closed", int'(window_open), 0);
        do_write(1'b0);
        chk("R10", "write ignored", int'(refresh_bad), 0);
        chk("R10", "no irq", int'(irq), 0);
        repeat (5) do_tick();
        chk("R10", "errors unchanged", int'(wd_err_cnt), 3);
        chk("R10", "no reset", int'(reset_req), 0);

        // R9 leaving disabled applies the code at once
        period_sel = 4'd0;
        wd_disable = 1'b0;
        step();
        chk("R9", "closed on exit", int'(window_open), 0);
        do_tick();
        chk("R9", "new half one tick", int'(window_open), 1);
        do_tick();
        chk("R7", "timeout bad", int'(refresh_bad), 1);
        chk("R7", "timeout count", int'(wd_err_cnt), 4);

        // R10 debug strap
        do_reset(1'b1);
        chk("R10", "strap off", int'(window_open), 0);
        do_write(1'b0);
        step();
        chk("R10", "strap no reset", int'(reset_req), 0);
        chk("R10", "strap no count", int'(rst_err_cnt), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule